// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns the decoded address fields of a memory-reference instruction into a byte effective address. It holds three banks of eight pointer registers: base registers for data references, array scratchpad registers for indirect array access, and code pointer registers for jumps. One shared write port loads all three banks. A request gives an addressing form, an index register number, a bank register number, the raw address field and the value read from the named index register. The index value is a signed element offset and is added without scaling.

The meaning of a zero index number depends on the form. With the long displacement it turns indexing off, so a constant-subscript element is reached as base plus displacement. With the short displacement it selects absolute addressing, and the whole address field is the address. The indirect post-indexed form adds a 12-bit offset to an array scratchpad register to locate a pointer in memory. It reads that pointer over a request/valid handshake and then adds the index value to it. The jump form uses the code pointer bank and counts its displacement in halfwords. A mode input picks 32-bit or 64-bit arithmetic for each request.

Top module: `idx_addr_gen`

## Requirements
- R1: After reset `addr_valid`, `mem_rd_req` and `busy` are low and `eff_addr` is zero.
- R2: Form code 0 (long) with a non-zero index number gives base register [bank sel] + field[27:0] (zero-extended) + index value. `addr_valid` rises the cycle after the request; field bits above 27 are ignored.
- R3: Form code 0 with index number 0 gives base + field[27:0], and the index value is ignored.
- R4: Form code 1 (short) with a non-zero index number gives base + field[15:0] (zero-extended) + index value.
- R5: Form code 1 with index number 0 is absolute: the whole field is the address, no base register is used, and the index value is ignored.
- R6: Form code 2 (indirect) raises `mem_rd_req` the cycle after the request, with address array register + field[11:0]. Request and address are held until `mem_rd_valid`. In the cycle after the response, `addr_valid` is high with pointer + index value, or the pointer alone when the index number is 0.
- R7: Form code 3 (jump) gives code pointer register + 2 × field[15:0] + index value, the index term being dropped when the index number is 0.
- R8: With `wide64` low all results wrap modulo 2^32 and bits 63:32 are zero. With it high they wrap modulo 2^64.
- R9: The index value is two's-complement signed, so a negative value lowers the address.
- R10: A request made while `busy` is high is ignored and does not disturb the pending indirect access or its result.
- R11: Write bank code 0 selects base, 1 array scratchpad and 2 code pointer registers. A write changes only the addressed register of the addressed bank, and a request in the following cycle sees it.
- R12: `addr_valid` is high for exactly one cycle per accepted request and is never high while `mem_rd_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide64 | input | 1 | 1 selects 64-bit arithmetic, 0 selects 32-bit |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_mode | input | 2 | Form: 0 long, 1 short, 2 indirect, 3 jump |
| req_idx_sel | input | 3 | Index register number, 0 means none |
| req_base_sel | input | 3 | Register number within the bank the form uses |
| req_field | input | 64 | Raw address field |
| req_idx_val | input | 64 | Value of the named index register |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 2 | Bank to write: 0 base, 1 array, 2 code pointer |
| wr_sel | input | 3 | Register number to write |
| wr_data | input | 64 | Write data |
| busy | output | 1 | Indirect access in progress |
| mem_rd_req | output | 1 | Pointer read request |
| mem_rd_addr | output | 64 | Pointer location |
| mem_rd_valid | input | 1 | Pointer read response strobe |
| mem_rd_data | input | 64 | Pointer value |
| addr_valid | output | 1 | Effective address valid, one cycle |
| eff_addr | output | 64 | Effective address |

## Verification
The bench targets the zero index number under both displacement forms with a non-zero index value present. A design that treated both forms alike would either add that stray value or add a base register to an absolute address. It drives carry across bit 31 and bit 63, and a negative index value, which catch a missing 32-bit mask or an unsigned extension. It stretches the indirect wait over several cycles and issues a competing request in the middle; a design that dropped its held request, let the new request through or lost the latched index would show a moved read address, an extra valid pulse or a wrong final address. It loads the same register number in all three banks to expose a bank decode or write-select fault.

// File: rtl/iea_pkg.sv
package iea_pkg;
   typedef enum logic [1:0] {
      AM_LONG  = 2'd0,
      AM_SHORT = 2'd1,
      AM_INDIR = 2'd2,
      AM_JUMP  = 2'd3
   } amode_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } agstate_t;

   localparam int NBANK = 3;
   localparam logic [1:0] BK_BASE  = 2'd0;
   localparam logic [1:0] BK_ARRAY = 2'd1;
   localparam logic [1:0] BK_CODE  = 2'd2;
endpackage

// File: rtl/iea_regbank.sv
module iea_regbank #(
   parameter int         N       = 8,
   parameter int         W       = 64,
   parameter int         SW      = 3,
   parameter logic [1:0] BANK_ID = 2'd0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_bank,
   input  logic [SW-1:0] wr_sel,
   input  logic [W-1:0]  wr_data,
   input  logic [SW-1:0] rd_sel,
   output logic [W-1:0]  rd_data
);
   logic [W-1:0] regs [N];
   logic         bank_hit;

   assign bank_hit = wr_en && (wr_bank == BANK_ID);

   for (genvar i = 0; i < N; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (bank_hit && (wr_sel == SW'(i)))
            regs[i] <= wr_data;
      end
   end

   assign rd_data = regs[rd_sel];
endmodule

// File: rtl/iea_calc.sv
module iea_calc
   import iea_pkg::*;
#(
   parameter int W   = 64,
   parameter int LDW = 28,
   parameter int SDW = 16,
   parameter int IDW = 12
) (
   input  amode_t       mode,
   input  logic         idx_zero,
   input  logic         wide,
   input  logic         post_wide,
   input  logic [W-1:0] field,
   input  logic [W-1:0] base_val,
   input  logic [W-1:0] arr_val,
   input  logic [W-1:0] code_val,
   input  logic [W-1:0] idx_val,
   input  logic [W-1:0] ptr_data,
   input  logic [W-1:0] post_idx,
   output logic [W-1:0] idx_term,
   output logic [W-1:0] ea_direct,
   output logic [W-1:0] ptr_loc,
   output logic [W-1:0] ea_post
);
   logic [W-1:0] disp_long, disp_short, disp_ind;
   logic [W-1:0] mask_cur, mask_post;
   logic [W-1:0] raw;

   assign disp_long  = W'(field[LDW-1:0]);
   assign disp_short = W'(field[SDW-1:0]);
   assign disp_ind   = W'(field[IDW-1:0]);
   assign idx_term   = idx_zero ? '0 : idx_val;

   if (W > 32) begin : g_narrow
      assign mask_cur  = wide      ? '1 : W'(32'hFFFF_FFFF);
      assign mask_post = post_wide ? '1 : W'(32'hFFFF_FFFF);
   end else begin : g_fixed
      assign mask_cur  = '1;
      assign mask_post = '1;
   end

   always_comb begin
      unique case (mode)
         AM_LONG:  raw = base_val + disp_long + idx_term;
         AM_SHORT: raw = idx_zero ? field : (base_val + disp_short + idx_val);
         AM_JUMP:  raw = code_val + (disp_short << 1) + idx_term;
         default:  raw = arr_val + disp_ind;
      endcase
   end

   assign ea_direct = raw & mask_cur;
   assign ptr_loc   = (arr_val + disp_ind) & mask_cur;
   assign ea_post   = (ptr_data + post_idx) & mask_post;
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
   import iea_pkg::*;
#(
   parameter int ADDR_W       = 64,
   parameter int NREG         = 8,
   parameter int LONG_DISP_W  = 28,
   parameter int SHORT_DISP_W = 16,
   parameter int IND_DISP_W   = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wide64,
   input  logic                     req_valid,
   input  logic [1:0]               req_mode,
   input  logic [$clog2(NREG)-1:0]  req_idx_sel,
   input  logic [$clog2(NREG)-1:0]  req_base_sel,
   input  logic [ADDR_W-1:0]        req_field,
   input  logic [ADDR_W-1:0]        req_idx_val,
   input  logic                     wr_en,
   input  logic [1:0]               wr_bank,
   input  logic [$clog2(NREG)-1:0]  wr_sel,
   input  logic [ADDR_W-1:0]        wr_data,
   output logic                     busy,
   output logic                     mem_rd_req,
   output logic [ADDR_W-1:0]        mem_rd_addr,
   input  logic                     mem_rd_valid,
   input  logic [ADDR_W-1:0]        mem_rd_data,
   output logic                     addr_valid,
   output logic [ADDR_W-1:0]        eff_addr
);
   localparam int SEL_W = $clog2(NREG);

   if (ADDR_W < 32) begin : g_bad_width
      $error("idx_addr_gen: ADDR_W must be at least 32");
   end
   if (NREG != (1 << SEL_W)) begin : g_bad_nreg
      $error("idx_addr_gen: NREG must be a power of two");
   end
   if (LONG_DISP_W >= ADDR_W || SHORT_DISP_W >= LONG_DISP_W || IND_DISP_W > SHORT_DISP_W) begin : g_bad_disp
      $error("idx_addr_gen: displacement widths out of order");
   end

   logic [ADDR_W-1:0] bank_rd [NBANK];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      iea_regbank #(
         .N       (NREG),
         .W       (ADDR_W),
         .SW      (SEL_W),
         .BANK_ID (2'(b))
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .wr_bank (wr_bank),
         .wr_sel  (wr_sel),
         .wr_data (wr_data),
         .rd_sel  (req_base_sel),
         .rd_data (bank_rd[b])
      );
   end

   agstate_t          state;
   amode_t            mode;
   logic              wide_q;
   logic [ADDR_W-1:0] post_idx_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] idx_term, ea_direct, ptr_loc, ea_post;

   assign mode = amode_t'(req_mode);

   iea_calc #(
      .W   (ADDR_W),
      .LDW (LONG_DISP_W),
      .SDW (SHORT_DISP_W),
      .IDW (IND_DISP_W)
   ) u_calc (
      .mode      (mode),
      .idx_zero  (req_idx_sel == '0),
      .wide      (wide64),
      .post_wide (wide_q),
      .field     (req_field),
      .base_val  (bank_rd[BK_BASE]),
      .arr_val   (bank_rd[BK_ARRAY]),
      .code_val  (bank_rd[BK_CODE]),
      .idx_val   (req_idx_val),
      .ptr_data  (mem_rd_data),
      .post_idx  (post_idx_q),
      .idx_term  (idx_term),
      .ea_direct (ea_direct),
      .ptr_loc   (ptr_loc),
      .ea_post   (ea_post)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         wide_q     <= 1'b0;
         post_idx_q <= '0;
         ptr_q      <= '0;
         addr_valid <= 1'b0;
         eff_addr   <= '0;
      end else begin
         addr_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  wide_q <= wide64;
                  if (mode == AM_INDIR) begin
                     ptr_q      <= ptr_loc;
                     post_idx_q <= idx_term;
                     state      <= ST_WAIT;
                  end else begin
                     eff_addr   <= ea_direct;
                     addr_valid <= 1'b1;
                  end
               end
            end
            default: begin
               if (mem_rd_valid) begin
                  eff_addr   <= ea_post;
                  addr_valid <= 1'b1;
                  state      <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign busy        = (state == ST_WAIT);
   assign mem_rd_req  = (state == ST_WAIT);
   assign mem_rd_addr = ptr_q;
endmodule

// File: rtl/iea_chk.sv
module iea_chk #(
   parameter int W = 64
) (
   input logic         clk,
   input logic         rst_n,
   input logic         req_valid,
   input logic [1:0]   req_mode,
   input logic         busy,
   input logic         mem_rd_req,
   input logic [W-1:0] mem_rd_addr,
   input logic         mem_rd_valid,
   input logic         addr_valid,
   input logic [W-1:0] eff_addr,
   input logic         wide_q
);
   AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr)); // R6

   AST_RESP_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req && mem_rd_valid |=> addr_valid && !mem_rd_req); // R6

   AST_NO_VALID_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !addr_valid); // R12

   AST_DIRECT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !busy && (req_mode != 2'd2) |=> addr_valid); // R2

   AST_INDIR_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !busy && (req_mode == 2'd2) |=> mem_rd_req && !addr_valid); // R6

   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mem_rd_valid |=> !addr_valid); // R10

   if (W > 32) begin : g_upper
      AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         addr_valid && !wide_q |-> eff_addr[W-1:32] == '0); // R8
   end
endmodule

bind idx_addr_gen iea_chk #(.W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_mode     (req_mode),
   .busy         (busy),
   .mem_rd_req   (mem_rd_req),
   .mem_rd_addr  (mem_rd_addr),
   .mem_rd_valid (mem_rd_valid),
   .addr_valid   (addr_valid),
   .eff_addr     (eff_addr),
   .wide_q       (wide_q)
);

// File: tb/idx_addr_gen_test.sv
module idx_addr_gen_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide64 = 1'b1;
   logic        req_valid = 1'b0;
   logic [1:0]  req_mode = 2'd0;
   logic [2:0]  req_idx_sel = 3'd0;
   logic [2:0]  req_base_sel = 3'd0;
   logic [63:0] req_field = '0;
   logic [63:0] req_idx_val = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_bank = 2'd0;
   logic [2:0]  wr_sel = 3'd0;
   logic [63:0] wr_data = '0;
   logic        busy, mem_rd_req, addr_valid;
   logic [63:0] mem_rd_addr, eff_addr;
   logic        mem_rd_valid = 1'b0;
   logic [63:0] mem_rd_data = '0;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   idx_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .wide64(wide64), .req_valid(req_valid),
      .req_mode(req_mode), .req_idx_sel(req_idx_sel), .req_base_sel(req_base_sel),
      .req_field(req_field), .req_idx_val(req_idx_val), .wr_en(wr_en),
      .wr_bank(wr_bank), .wr_sel(wr_sel), .wr_data(wr_data), .busy(busy),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
      .mem_rd_data(mem_rd_data), .addr_valid(addr_valid), .eff_addr(eff_addr)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] bank, input logic [2:0] sel, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_bank = bank; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic dreq(input string tag, input logic [1:0] m, input logic [2:0] is,
                       input logic [2:0] bs, input logic [63:0] f, input logic [63:0] iv,
                       input logic w, input logic [63:0] exp);
      @(negedge clk);
      req_mode = m; req_idx_sel = is; req_base_sel = bs; req_field = f;
      req_idx_val = iv; wide64 = w; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " valid"}, 64'(addr_valid), 64'd1);
      chk(tag, eff_addr, exp);
      @(negedge clk);
      chk({tag, " R12 single pulse"}, 64'(addr_valid), 64'd0);
   endtask

   task automatic ireq(input string tag, input logic [2:0] is, input logic [2:0] bs,
                       input logic [63:0] f, input logic [63:0] iv, input logic w,
                       input logic [63:0] exp_loc, input logic [63:0] ptr,
                       input logic [63:0] exp_ea, input int nwait, input bit intrude);
      @(negedge clk);
      req_mode = 2'd2; req_idx_sel = is; req_base_sel = bs; req_field = f;
      req_idx_val = iv; wide64 = w; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_idx_val = 64'hDEAD_0000_0000_BEEF;
      chk({tag, " R6 read request"}, 64'(mem_rd_req), 64'd1);
      chk({tag, " R6 read address"}, mem_rd_addr, exp_loc);
      chk({tag, " R10 busy"}, 64'(busy), 64'd1);
      for (int i = 0; i < nwait; i++) begin
         if (intrude && i == 0) begin
            req_mode = 2'd0; req_idx_sel = 3'd0; req_base_sel = 3'd1;
            req_field = 64'h40; req_valid = 1'b1;
         end
         @(negedge clk);
         req_valid = 1'b0;
         chk({tag, " R6 request held"}, 64'(mem_rd_req), 64'd1);
         chk({tag, " R6 address held"}, mem_rd_addr, exp_loc);
         chk({tag, " R10 no early valid"}, 64'(addr_valid), 64'd0);
      end
      mem_rd_valid = 1'b1; mem_rd_data = ptr;
      @(negedge clk);
      mem_rd_valid = 1'b0; mem_rd_data = '0;
      chk({tag, " R6 valid"}, 64'(addr_valid), 64'd1);
      chk({tag, " R6 address"}, eff_addr, exp_ea);
      chk({tag, " R6 request dropped"}, 64'(mem_rd_req), 64'd0);
      @(negedge clk);
      chk({tag, " R12 single pulse"}, 64'(addr_valid), 64'd0);
      chk({tag, " R10 result kept"}, eff_addr, exp_ea);
   endtask

   task automatic t_reset;
      chk("R1 addr_valid", 64'(addr_valid), 64'd0);
      chk("R1 mem_rd_req", 64'(mem_rd_req), 64'd0);
      chk("R1 busy", 64'(busy), 64'd0);
      chk("R1 eff_addr", eff_addr, 64'd0);
   endtask

   task automatic t_setup;
      wr(2'd0, 3'd1, 64'h0000_0000_1000_0000);
      wr(2'd0, 3'd2, 64'h0000_0000_FFFF_FFF0);
      wr(2'd0, 3'd6, 64'hFFFF_FFFF_FFFF_FFF0);
      wr(2'd1, 3'd3, 64'h0000_0000_0000_2000);
      wr(2'd2, 3'd5, 64'h0000_0000_0000_4000);
      wr(2'd0, 3'd5, 64'h0000_0000_0900_0000);
   endtask

   task automatic t_long;
      dreq("R2 long indexed", 2'd0, 3'd4, 3'd1, 64'h0ABC_DEF, 64'h10, 1'b1, 64'h0000_0000_10AB_CDFF);
      dreq("R2 long upper field ignored", 2'd0, 3'd4, 3'd1, 64'hF000_0100, 64'h10, 1'b1, 64'h0000_0000_1000_0110);
      dreq("R3 long no index", 2'd0, 3'd0, 3'd1, 64'h0000_0200, 64'h5555, 1'b1, 64'h0000_0000_1000_0200);
   endtask

   task automatic t_short;
      dreq("R4 short based", 2'd1, 3'd2, 3'd1, 64'h1234_8000, 64'h20, 1'b1, 64'h0000_0000_1000_8020);
      dreq("R5 absolute wide", 2'd1, 3'd0, 3'd1, 64'h1122_3344_5566_7788, 64'h999, 1'b1, 64'h1122_3344_5566_7788);
      dreq("R5 absolute narrow", 2'd1, 3'd0, 3'd1, 64'h1122_3344_5566_7788, 64'h999, 1'b0, 64'h0000_0000_5566_7788);
   endtask

   task automatic t_wrap;
      dreq("R8 wrap 32", 2'd0, 3'd0, 3'd2, 64'h20, 64'h0, 1'b0, 64'h0000_0000_0000_0010);
      dreq("R8 carry in 64", 2'd0, 3'd0, 3'd2, 64'h20, 64'h0, 1'b1, 64'h0000_0001_0000_0010);
      dreq("R8 wrap 64", 2'd0, 3'd0, 3'd6, 64'h20, 64'h0, 1'b1, 64'h0000_0000_0000_0010);
   endtask

   task automatic t_neg_index;
      dreq("R9 negative index wide", 2'd0, 3'd3, 3'd1, 64'h100, 64'hFFFF_FFFF_FFFF_FFC0, 1'b1, 64'h0000_0000_1000_00C0);
      dreq("R9 negative index narrow", 2'd0, 3'd3, 3'd1, 64'h100, 64'hFFFF_FFFF_FFFF_FFC0, 1'b0, 64'h0000_0000_1000_00C0);
   endtask

   task automatic t_jump;
      dreq("R7 jump halfword disp", 2'd3, 3'd0, 3'd5, 64'h0100, 64'h77, 1'b1, 64'h0000_0000_0000_4200);
      dreq("R7 jump indexed", 2'd3, 3'd1, 3'd5, 64'h0100, 64'h6, 1'b1, 64'h0000_0000_0000_4206);
   endtask

   task automatic t_indirect;
      ireq("R6 indirect indexed", 3'd1, 3'd3, 64'h5678_9ABC, 64'h8, 1'b1,
           64'h0000_0000_0000_2ABC, 64'h7000_0000_0000_0000, 64'h7000_0000_0000_0008, 3, 1'b0);
      ireq("R6 indirect no index", 3'd0, 3'd3, 64'h010, 64'h8, 1'b1,
           64'h0000_0000_0000_2010, 64'h0000_0000_3000_0000, 64'h0000_0000_3000_0000, 1, 1'b0);
      ireq("R10 busy request ignored", 3'd2, 3'd3, 64'h004, 64'h1, 1'b0,
           64'h0000_0000_0000_2004, 64'h0000_0005_8000_0000, 64'h0000_0000_8000_0001, 2, 1'b1);
   endtask

   task automatic t_banks;
      wr(2'd0, 3'd4, 64'h0000_0000_00AA_0000);
      wr(2'd1, 3'd4, 64'h0000_0000_00BB_0000);
      wr(2'd2, 3'd4, 64'h0000_0000_00CC_0000);
      dreq("R11 base bank", 2'd0, 3'd0, 3'd4, 64'h0, 64'h0, 1'b1, 64'h0000_0000_00AA_0000);
      dreq("R11 code bank", 2'd3, 3'd0, 3'd4, 64'h0, 64'h0, 1'b1, 64'h0000_0000_00CC_0000);
      ireq("R11 array bank", 3'd0, 3'd4, 64'h0, 64'h0, 1'b1,
           64'h0000_0000_00BB_0000, 64'h1234, 64'h1234, 0, 1'b0);
      dreq("R11 neighbour untouched", 2'd0, 3'd0, 3'd1, 64'h0, 64'h0, 1'b1, 64'h0000_0000_1000_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_setup();
      t_long();
      t_short();
      t_wrap();
      t_neg_index();
      t_jump();
      t_indirect();
      t_banks();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule